// File: doc/BRIEF.md
# Execute-Phase Sequencer with Per-Class Delay Slots

This block follows each issued instruction through ten execute phases and raises each instruction's side effects in the phase that belongs to its class. One instruction may issue in every cycle. An instruction carries a 3-bit class code, a predicate result, a destination register number, two operand values and a branch target. The block drives three kinds of output. The first is a pair of register-file write ports. The second is three memory-side channels: request, access and data return. The third is a branch redirect.

The classes take their effects at different depths. The arithmetic class writes in the first phase and the 16x16 multiply in the second. A store finishes its memory traffic by the third phase. A load writes its register in the fifth phase, and a branch redirects fetch in the sixth. Because of this, writes from separate instructions can land together. The block places the landing writes on its two ports, oldest first. It raises a clash flag when two landing writes name the same register, and also when more than two land in one cycle. Memory, register file and fetch are outside the block. The block exports strobes and values only, and it takes load data from a return bus.

Phase Ek of an instruction is the k-th cycle after the clock edge that samples its issue.

Top module: `exec_phase_seq`

## Requirements
- R1: A class-1 (arithmetic) instruction with a true predicate writes opa+opb (modulo 2^32) to its destination during E1.
- R2: A class-2 (multiply) instruction with a true predicate writes the signed product of the low 16 bits of opa and opb, sign-extended to 32 bits, during E2.
- R3: A class-3 (store) instruction raises a memory request during E2 with write-enable 1, address opa+opb and write data opb. It raises an access strobe with the same address and write-enable during E3. It writes no register.
- R4: A class-4 (load) instruction raises a request during E2 with write-enable 0 and address opa+opb. It raises an access strobe during E3 and a data-return strobe during E4. It writes the value on the return bus during E4 into its destination during E5.
- R5: A class-5 (branch) instruction raises the redirect during E6, carrying its target. Branches issued in consecutive cycles each redirect in their own E6, in issue order.
- R6: An instruction with a false predicate, class 0, or the spare codes 6 and 7 produces no register write, memory strobe or redirect in any phase.
- R7: Landing writes are assigned to ports by age: a load in E5 first, then a multiply in E2, then an arithmetic instruction in E1. Port 1 is used only when port 0 is also used.
- R8: The clash flag is high in a cycle where two landing writes name the same register, or where three writes land. In the three-write case, the arithmetic write is dropped.
- R9: Synchronous active-high reset discards every instruction in flight, and no strobe is high while reset is asserted or in the cycle after its release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is presented this cycle |
| iss_kind | input | 3 | Class code (0 none, 1 arith, 2 multiply, 3 store, 4 load, 5 branch) |
| iss_pred | input | 1 | Predicate result; 0 cancels the instruction |
| iss_dst | input | 5 | Destination register number |
| iss_opa | input | 32 | First operand |
| iss_opb | input | 32 | Second operand, also store data |
| iss_target | input | 32 | Branch target |
| mem_rdata | input | 32 | Load return data, sampled at the end of E4 |
| rf0_we | output | 1 | Write port 0 enable |
| rf0_idx | output | 5 | Write port 0 register |
| rf0_data | output | 32 | Write port 0 value |
| rf1_we | output | 1 | Write port 1 enable |
| rf1_idx | output | 5 | Write port 1 register |
| rf1_data | output | 32 | Write port 1 value |
| rf_clash | output | 1 | Same-register or excess write in this cycle |
| mreq_vld | output | 1 | Memory request strobe (E2) |
| mreq_we | output | 1 | Request is a write |
| mreq_addr | output | 32 | Request address |
| mreq_wdata | output | 32 | Store data |
| macc_vld | output | 1 | Memory access strobe (E3) |
| macc_we | output | 1 | Access is a write |
| macc_addr | output | 32 | Access address |
| mret_vld | output | 1 | Load data return strobe (E4) |
| redir_vld | output | 1 | Branch redirect strobe (E6) |
| redir_pc | output | 32 | Redirect target |

## Verification
Each result is due a fixed number of cycles after its issue edge. The arithmetic write comes 1 cycle later and the multiply write 2 cycles later. Memory requests come at 2 cycles and accesses at 3. Load returns come at 4 and load writes at 5, and redirects at 6. The bench keeps a sixteen-entry ring of issued instructions, one entry per cycle. On the falling edge after sampling edge m, it builds every expected output from the ring entry issued at m-k+1 for phase Ek, so each check compares the outputs against the one instruction that must be in that phase. Return data is a known function of the cycle number, so the load value expected in E5 is the bus value driven during that load's E4 cycle.

// File: rtl/esq_pkg.sv
`timescale 1ns/1ps
package esq_pkg;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_ARI  = 3'd1,
        K_MUL  = 3'd2,
        K_STO  = 3'd3,
        K_LDW  = 3'd4,
        K_BRA  = 3'd5
    } kind_e;

    // Phase positions in the token shift register (index 0 holds E1).
    localparam int PH_E1 = 0;
    localparam int PH_E2 = 1;
    localparam int PH_E3 = 2;
    localparam int PH_E4 = 3;
    localparam int PH_E5 = 4;
    localparam int PH_E6 = 5;
    localparam int PH_MIN = 6;

    // Spare codes behave as a no-operation.
    function automatic kind_e norm_kind(input logic [2:0] code);
        case (code)
            3'd1:    return K_ARI;
            3'd2:    return K_MUL;
            3'd3:    return K_STO;
            3'd4:    return K_LDW;
            3'd5:    return K_BRA;
            default: return K_NONE;
        endcase
    endfunction

    function automatic logic is_mem(input logic [2:0] k);
        return (k == K_STO) || (k == K_LDW);
    endfunction

endpackage

// File: rtl/esq_stage_pipe.sv
`timescale 1ns/1ps
module esq_stage_pipe
    import esq_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RIDX   = 5,
    parameter int NSTAGE = 10
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_vld,
    input  logic [2:0]                       in_kind,
    input  logic                             in_pred,
    input  logic [RIDX-1:0]                  in_dst,
    input  logic [XLEN-1:0]                  in_a,
    input  logic [XLEN-1:0]                  in_b,
    input  logic [XLEN-1:0]                  in_tgt,
    input  logic [XLEN-1:0]                  ret_data,
    output logic [NSTAGE-1:0]                ph_vld,
    output logic [NSTAGE-1:0][2:0]           ph_kind,
    output logic [NSTAGE-1:0][RIDX-1:0]      ph_dst,
    output logic [NSTAGE-1:0][XLEN-1:0]      ph_a,
    output logic [NSTAGE-1:0][XLEN-1:0]      ph_b
);

    typedef struct packed {
        logic [NSTAGE-1:0]           vld;
        logic [NSTAGE-1:0][2:0]      kind;
        logic [NSTAGE-1:0][RIDX-1:0] dst;
        logic [NSTAGE-1:0][XLEN-1:0] a;
        logic [NSTAGE-1:0][XLEN-1:0] b;
    } pipe_t;

    pipe_t st_d, st_q;
    kind_e in_norm;

    always_comb begin
        in_norm = norm_kind(in_kind);
        st_d    = st_q;

        // Entry into E1: cancelled or empty instructions never take a token.
        st_d.vld[PH_E1]  = in_vld && in_pred && (in_norm != K_NONE);
        st_d.kind[PH_E1] = in_norm;
        st_d.dst[PH_E1]  = in_dst;
        st_d.a[PH_E1]    = (in_norm == K_BRA) ? in_tgt : in_a;
        st_d.b[PH_E1]    = in_b;

        for (int j = 1; j < NSTAGE; j++) begin
            st_d.vld[j]  = st_q.vld[j-1];
            st_d.kind[j] = st_q.kind[j-1];
            st_d.dst[j]  = st_q.dst[j-1];
            st_d.a[j]    = st_q.a[j-1];
            st_d.b[j]    = st_q.b[j-1];
        end

        // Address generation happens in E1 and is carried into E2 onwards.
        if (is_mem(st_q.kind[PH_E1]))
            st_d.a[PH_E2] = st_q.a[PH_E1] + st_q.b[PH_E1];

        // Load data returned during E4 is held for the E5 write.
        if (st_q.kind[PH_E4] == K_LDW)
            st_d.b[PH_E5] = ret_data;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ph_vld  = st_q.vld;
    assign ph_kind = st_q.kind;
    assign ph_dst  = st_q.dst;
    assign ph_a    = st_q.a;
    assign ph_b    = st_q.b;

    // R6: a cancelled instruction never occupies E1.
    a_r6_pred_cancel: assert property (@(posedge clk) disable iff (rst)
        ($past(in_vld) && !$past(in_pred)) |-> !st_q.vld[PH_E1]);

    // R1: every token advances by exactly one phase per cycle.
    a_r1_advance: assert property (@(posedge clk) disable iff (rst)
        st_q.vld[PH_E1] |=> (st_q.vld[PH_E2]
                             && st_q.kind[PH_E2] == $past(st_q.kind[PH_E1])
                             && st_q.dst[PH_E2]  == $past(st_q.dst[PH_E1])));

    // R4: a load keeps its address through the memory phases.
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q.vld[PH_E2] && st_q.kind[PH_E2] == K_LDW)
            |=> st_q.a[PH_E3] == $past(st_q.a[PH_E2]));

endmodule

// File: rtl/esq_wr_arb.sv
`timescale 1ns/1ps
module esq_wr_arb #(
    parameter int XLEN  = 32,
    parameter int RIDX  = 5,
    parameter int NCAND = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NCAND-1:0]            c_en,
    input  logic [NCAND-1:0][RIDX-1:0]  c_idx,
    input  logic [NCAND-1:0][XLEN-1:0]  c_dat,
    output logic                        p0_we,
    output logic [RIDX-1:0]             p0_idx,
    output logic [XLEN-1:0]             p0_dat,
    output logic                        p1_we,
    output logic [RIDX-1:0]             p1_idx,
    output logic [XLEN-1:0]             p1_dat,
    output logic                        clash
);

    localparam int NPORT = 2;
    localparam int CW    = $clog2(NCAND + 1);

    logic [NCAND-1:0][NCAND-1:0] same_hit;
    logic [CW-1:0]               n_land;

    // Pairwise destination compare; only the upper triangle is meaningful.
    for (genvar i = 0; i < NCAND; i++) begin : g_row
        for (genvar j = 0; j < NCAND; j++) begin : g_col
            if (j > i) begin : g_pair
                assign same_hit[i][j] = c_en[i] && c_en[j] && (c_idx[i] == c_idx[j]);
            end else begin : g_none
                assign same_hit[i][j] = 1'b0;
            end
        end
    end

    // Candidates arrive oldest first; ports are filled in that order.
    always_comb begin
        p0_we  = 1'b0;
        p0_idx = '0;
        p0_dat = '0;
        p1_we  = 1'b0;
        p1_idx = '0;
        p1_dat = '0;
        n_land = '0;
        for (int i = 0; i < NCAND; i++) begin
            if (c_en[i]) begin
                n_land = n_land + 1'b1;
                if (!p0_we) begin
                    p0_we  = 1'b1;
                    p0_idx = c_idx[i];
                    p0_dat = c_dat[i];
                end else if (!p1_we) begin
                    p1_we  = 1'b1;
                    p1_idx = c_idx[i];
                    p1_dat = c_dat[i];
                end
            end
        end
        clash = (|same_hit) || (n_land > CW'(NPORT));
    end

    // R7: port 1 is only used behind port 0.
    a_r7_fill_order: assert property (@(posedge clk) disable iff (rst)
        p1_we |-> p0_we);

    // R7: any landing write reaches a port.
    a_r7_no_loss: assert property (@(posedge clk) disable iff (rst)
        (c_en != '0) |-> p0_we);

    // R8: two port writes to one register must be flagged.
    a_r8_same_reg: assert property (@(posedge clk) disable iff (rst)
        (p0_we && p1_we && p0_idx == p1_idx) |-> clash);

    // R8: more landing writes than ports must be flagged.
    a_r8_excess: assert property (@(posedge clk) disable iff (rst)
        ($countones(c_en) > NPORT) |-> clash);

endmodule

// File: rtl/exec_phase_seq.sv
`timescale 1ns/1ps
module exec_phase_seq
    import esq_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NREG   = 32,
    parameter int MULW   = 16,
    parameter int NSTAGE = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     iss_valid,
    input  logic [2:0]               iss_kind,
    input  logic                     iss_pred,
    input  logic [$clog2(NREG)-1:0]  iss_dst,
    input  logic [XLEN-1:0]          iss_opa,
    input  logic [XLEN-1:0]          iss_opb,
    input  logic [XLEN-1:0]          iss_target,
    input  logic [XLEN-1:0]          mem_rdata,
    output logic                     rf0_we,
    output logic [$clog2(NREG)-1:0]  rf0_idx,
    output logic [XLEN-1:0]          rf0_data,
    output logic                     rf1_we,
    output logic [$clog2(NREG)-1:0]  rf1_idx,
    output logic [XLEN-1:0]          rf1_data,
    output logic                     rf_clash,
    output logic                     mreq_vld,
    output logic                     mreq_we,
    output logic [XLEN-1:0]          mreq_addr,
    output logic [XLEN-1:0]          mreq_wdata,
    output logic                     macc_vld,
    output logic                     macc_we,
    output logic [XLEN-1:0]          macc_addr,
    output logic                     mret_vld,
    output logic                     redir_vld,
    output logic [XLEN-1:0]          redir_pc
);

    localparam int RIDX  = $clog2(NREG);
    localparam int NCAND = 3;
    localparam int CD_LD = 0;   // oldest landing write
    localparam int CD_MU = 1;
    localparam int CD_AR = 2;   // youngest landing write

    logic [NSTAGE-1:0]           ph_vld;
    logic [NSTAGE-1:0][2:0]      ph_kind;
    logic [NSTAGE-1:0][RIDX-1:0] ph_dst;
    logic [NSTAGE-1:0][XLEN-1:0] ph_a;
    logic [NSTAGE-1:0][XLEN-1:0] ph_b;

    logic [NCAND-1:0]            c_en;
    logic [NCAND-1:0][RIDX-1:0]  c_idx;
    logic [NCAND-1:0][XLEN-1:0]  c_dat;
    logic signed [2*MULW-1:0]    mul_full;
    logic                        live;

    esq_stage_pipe #(
        .XLEN   (XLEN),
        .RIDX   (RIDX),
        .NSTAGE (NSTAGE)
    ) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (iss_valid),
        .in_kind  (iss_kind),
        .in_pred  (iss_pred),
        .in_dst   (iss_dst),
        .in_a     (iss_opa),
        .in_b     (iss_opb),
        .in_tgt   (iss_target),
        .ret_data (mem_rdata),
        .ph_vld   (ph_vld),
        .ph_kind  (ph_kind),
        .ph_dst   (ph_dst),
        .ph_a     (ph_a),
        .ph_b     (ph_b)
    );

    always_comb begin
        live     = !rst;
        mul_full = $signed(ph_a[PH_E2][MULW-1:0]) * $signed(ph_b[PH_E2][MULW-1:0]);

        c_en[CD_LD]  = live && ph_vld[PH_E5] && (ph_kind[PH_E5] == K_LDW);
        c_idx[CD_LD] = ph_dst[PH_E5];
        c_dat[CD_LD] = ph_b[PH_E5];

        c_en[CD_MU]  = live && ph_vld[PH_E2] && (ph_kind[PH_E2] == K_MUL);
        c_idx[CD_MU] = ph_dst[PH_E2];
        c_dat[CD_MU] = XLEN'(mul_full);

        c_en[CD_AR]  = live && ph_vld[PH_E1] && (ph_kind[PH_E1] == K_ARI);
        c_idx[CD_AR] = ph_dst[PH_E1];
        c_dat[CD_AR] = ph_a[PH_E1] + ph_b[PH_E1];

        mreq_vld   = live && ph_vld[PH_E2] && is_mem(ph_kind[PH_E2]);
        mreq_we    = ph_kind[PH_E2] == K_STO;
        mreq_addr  = ph_a[PH_E2];
        mreq_wdata = ph_b[PH_E2];

        macc_vld   = live && ph_vld[PH_E3] && is_mem(ph_kind[PH_E3]);
        macc_we    = ph_kind[PH_E3] == K_STO;
        macc_addr  = ph_a[PH_E3];

        mret_vld   = live && ph_vld[PH_E4] && (ph_kind[PH_E4] == K_LDW);

        redir_vld  = live && ph_vld[PH_E6] && (ph_kind[PH_E6] == K_BRA);
        redir_pc   = ph_a[PH_E6];
    end

    esq_wr_arb #(
        .XLEN  (XLEN),
        .RIDX  (RIDX),
        .NCAND (NCAND)
    ) u_arb (
        .clk    (clk),
        .rst    (rst),
        .c_en   (c_en),
        .c_idx  (c_idx),
        .c_dat  (c_dat),
        .p0_we  (rf0_we),
        .p0_idx (rf0_idx),
        .p0_dat (rf0_data),
        .p1_we  (rf1_we),
        .p1_idx (rf1_idx),
        .p1_dat (rf1_data),
        .clash  (rf_clash)
    );

    // R3: an access follows every request one cycle later at the same address.
    a_r3_acc_follows_req: assert property (@(posedge clk) disable iff (rst)
        mreq_vld |=> (macc_vld && macc_addr == $past(mreq_addr)
                      && macc_we == $past(mreq_we)));

    // R4: a data return only follows a read access.
    a_r4_ret_after_read: assert property (@(posedge clk) disable iff (rst)
        mret_vld |-> ($past(macc_vld) && !$past(macc_we)));

    // R5: a redirect comes from a live branch issued six edges earlier.
    a_r5_redirect_src: assert property (@(posedge clk) disable iff (rst)
        redir_vld |-> $past(iss_valid && iss_pred && iss_kind == 3'd5, 6));

    // R9: nothing survives a reset into the first cycle after it.
    a_r9_post_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(rf0_we || rf1_we || mreq_vld || macc_vld
                         || mret_vld || redir_vld || rf_clash));

endmodule

// File: tb/sim_exec_phase_seq.sv
`timescale 1ns/1ps
module sim_exec_phase_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        iss_valid;
    logic [2:0]  iss_kind;
    logic        iss_pred;
    logic [4:0]  iss_dst;
    logic [31:0] iss_opa, iss_opb, iss_target, mem_rdata;
    logic        rf0_we, rf1_we, rf_clash;
    logic [4:0]  rf0_idx, rf1_idx;
    logic [31:0] rf0_data, rf1_data;
    logic        mreq_vld, mreq_we, macc_vld, macc_we, mret_vld, redir_vld;
    logic [31:0] mreq_addr, mreq_wdata, macc_addr, redir_pc;

    always #2.5 clk = ~clk;

    exec_phase_seq u0 (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_kind(iss_kind),
        .iss_pred(iss_pred), .iss_dst(iss_dst), .iss_opa(iss_opa),
        .iss_opb(iss_opb), .iss_target(iss_target), .mem_rdata(mem_rdata),
        .rf0_we(rf0_we), .rf0_idx(rf0_idx), .rf0_data(rf0_data),
        .rf1_we(rf1_we), .rf1_idx(rf1_idx), .rf1_data(rf1_data),
        .rf_clash(rf_clash), .mreq_vld(mreq_vld), .mreq_we(mreq_we),
        .mreq_addr(mreq_addr), .mreq_wdata(mreq_wdata), .macc_vld(macc_vld),
        .macc_we(macc_we), .macc_addr(macc_addr), .mret_vld(mret_vld),
        .redir_vld(redir_vld), .redir_pc(redir_pc)
    );

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    // Ring of sampled issues; entry m holds what the edge m sampled.
    bit          hv [16];
    logic [2:0]  hk [16];
    logic [4:0]  hd [16];
    logic [31:0] ha [16], hb [16], ht [16];

    initial for (int i = 0; i < 16; i++) hv[i] = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            for (int i = 0; i < 16; i++) hv[i] <= 1'b0;
        end else begin
            hv[(cyc + 1) & 15] <= iss_valid && iss_pred && iss_kind >= 3'd1 && iss_kind <= 3'd5;
            hk[(cyc + 1) & 15] <= iss_kind;
            hd[(cyc + 1) & 15] <= iss_dst;
            ha[(cyc + 1) & 15] <= iss_opa;
            hb[(cyc + 1) & 15] <= iss_opb;
            ht[(cyc + 1) & 15] <= iss_target;
        end
    end

    function automatic logic [31:0] rdv(input int m);
        return (32'(m) * 32'h9E37_79B1) ^ 32'h0F0F_1234;
    endfunction

    function automatic logic [31:0] mul16(input logic [31:0] a, input logic [31:0] b);
        int p;
        p = int'($signed(a[15:0])) * int'($signed(b[15:0]));
        return 32'(p);
    endfunction

    task automatic expect_eq(input string req, input string what,
                             input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", req, what, cyc, act, exp);
        end
    endtask

    function automatic int slot(input int m, input int ph);
        return (m - ph + 1) & 15;
    endfunction

    task automatic check_cycle();
        int m, s;
        bit   ce [3];
        logic [4:0]  ci [3];
        logic [31:0] cd [3];
        string       cr [3];
        bit   w0, w1, clash_e;
        logic [4:0]  i0, i1;
        logic [31:0] d0, d1;
        string r0, r1, rq;
        int n;
        m = cyc;
        if (rst) begin
            expect_eq("R9", "strobes in reset",
                      96'({rf0_we, rf1_we, rf_clash, mreq_vld, macc_vld, mret_vld, redir_vld}), 96'(0));
            return;
        end
        // Oldest first: load in E5, multiply in E2, arithmetic in E1.
        s = slot(m, 5); ce[0] = hv[s] && hk[s] == 3'd4; ci[0] = hd[s]; cd[0] = rdv(m - 1); cr[0] = "R4";
        s = slot(m, 2); ce[1] = hv[s] && hk[s] == 3'd2; ci[1] = hd[s]; cd[1] = mul16(ha[s], hb[s]); cr[1] = "R2";
        s = slot(m, 1); ce[2] = hv[s] && hk[s] == 3'd1; ci[2] = hd[s]; cd[2] = ha[s] + hb[s]; cr[2] = "R1";
        w0 = 0; w1 = 0; i0 = 0; i1 = 0; d0 = 0; d1 = 0; r0 = "R7"; r1 = "R7"; n = 0;
        for (int i = 0; i < 3; i++) begin
            if (ce[i]) begin
                n++;
                if (!w0) begin w0 = 1; i0 = ci[i]; d0 = cd[i]; r0 = cr[i]; end
                else if (!w1) begin w1 = 1; i1 = ci[i]; d1 = cd[i]; r1 = cr[i]; end
            end
        end
        clash_e = (n > 2);
        for (int i = 0; i < 3; i++)
            for (int j = i + 1; j < 3; j++)
                if (ce[i] && ce[j] && ci[i] == ci[j]) clash_e = 1;
        expect_eq(r0, "port0 {we,idx,data}",
                  96'({rf0_we, rf0_we ? rf0_idx : 5'd0, rf0_we ? rf0_data : 32'd0}),
                  96'({w0, i0, d0}));
        expect_eq(r1, "port1 {we,idx,data}",
                  96'({rf1_we, rf1_we ? rf1_idx : 5'd0, rf1_we ? rf1_data : 32'd0}),
                  96'({w1, i1, d1}));
        expect_eq("R8", "clash", 96'(rf_clash), 96'(clash_e));
        // E2 request
        s = slot(m, 2);
        rq = (hv[s] && hk[s] == 3'd3) ? "R3" : (hv[s] && hk[s] == 3'd4) ? "R4" : "R6";
        if (hv[s] && (hk[s] == 3'd3 || hk[s] == 3'd4))
            expect_eq(rq, "request {vld,we,addr,wdata}",
                      96'({mreq_vld, mreq_we, mreq_addr, mreq_we ? mreq_wdata : 32'd0}),
                      96'({1'b1, hk[s] == 3'd3, ha[s] + hb[s], hk[s] == 3'd3 ? hb[s] : 32'd0}));
        else
            expect_eq(rq, "request idle", 96'(mreq_vld), 96'(0));
        // E3 access
        s = slot(m, 3);
        rq = (hv[s] && hk[s] == 3'd3) ? "R3" : (hv[s] && hk[s] == 3'd4) ? "R4" : "R6";
        if (hv[s] && (hk[s] == 3'd3 || hk[s] == 3'd4))
            expect_eq(rq, "access {vld,we,addr}",
                      96'({macc_vld, macc_we, macc_addr}),
                      96'({1'b1, hk[s] == 3'd3, ha[s] + hb[s]}));
        else
            expect_eq(rq, "access idle", 96'(macc_vld), 96'(0));
        // E4 return
        s = slot(m, 4);
        expect_eq("R4", "return strobe", 96'(mret_vld), 96'(hv[s] && hk[s] == 3'd4));
        // E6 redirect
        s = slot(m, 6);
        if (hv[s] && hk[s] == 3'd5)
            expect_eq("R5", "redirect {vld,pc}", 96'({redir_vld, redir_pc}), 96'({1'b1, ht[s]}));
        else
            expect_eq("R5", "redirect idle", 96'(redir_vld), 96'(0));
    endtask

    task automatic tick();
        @(negedge clk);
        check_cycle();
        mem_rdata = rdv(cyc);
    endtask

    task automatic put(input logic [2:0] k, input logic p, input logic [4:0] d,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] t);
        iss_valid = 1'b1; iss_kind = k; iss_pred = p; iss_dst = d;
        iss_opa = a; iss_opb = b; iss_target = t;
        tick();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            iss_valid = 1'b0; iss_kind = 3'($urandom); iss_pred = 1'b1;
            iss_dst = 5'($urandom); iss_opa = $urandom; iss_opb = $urandom;
            iss_target = $urandom;
            tick();
        end
    endtask

    initial begin
        #(200000.0 * 5.0 / 2.0);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; mem_rdata = '0;
        idle(4);                                          // R9 while reset is high
        rst = 1'b0;
        // R1 arithmetic, including carry wrap
        put(3'd1, 1, 5'd3, 32'd5, 32'd7, 32'd0);
        put(3'd1, 1, 5'd4, 32'hFFFF_FFFF, 32'd2, 32'd0);
        idle(2);
        // R2 multiply with upper operand bits that must not matter
        put(3'd2, 1, 5'd6, 32'hABCD_FFFD, 32'h1234_0004, 32'd0);
        idle(3);
        // R3 store then R4 load
        put(3'd3, 1, 5'd1, 32'h0000_1000, 32'h0000_0020, 32'd0);
        put(3'd4, 1, 5'd9, 32'h0000_2000, 32'h0000_0008, 32'd0);
        idle(7);
        // R8 three landing writes: load E5, multiply E2, arithmetic E1
        put(3'd4, 1, 5'd12, 32'd64, 32'd0, 32'd0);
        idle(2);
        put(3'd2, 1, 5'd13, 32'd3, 32'd5, 32'd0);
        put(3'd1, 1, 5'd14, 32'd1, 32'd1, 32'd0);
        idle(6);
        // R8 same-register pair: load and arithmetic both to 20
        put(3'd4, 1, 5'd20, 32'd16, 32'd0, 32'd0);
        idle(3);
        put(3'd1, 1, 5'd20, 32'd9, 32'd9, 32'd0);
        idle(6);
        // R5 back-to-back branches
        put(3'd5, 1, 5'd0, 32'd0, 32'd0, 32'h0000_4000);
        put(3'd5, 1, 5'd0, 32'd0, 32'd0, 32'h0000_5000);
        idle(8);
        // R6 cancelled and empty codes
        put(3'd1, 0, 5'd2, 32'd1, 32'd2, 32'd0);
        put(3'd4, 0, 5'd2, 32'd1, 32'd2, 32'd0);
        put(3'd5, 0, 5'd2, 32'd1, 32'd2, 32'h0000_6000);
        put(3'd6, 1, 5'd2, 32'd1, 32'd2, 32'd0);
        put(3'd7, 1, 5'd2, 32'd1, 32'd2, 32'd0);
        put(3'd0, 1, 5'd2, 32'd1, 32'd2, 32'd0);
        idle(8);
        // R9 reset while a load and a branch are in flight
        put(3'd4, 1, 5'd7, 32'd8, 32'd8, 32'd0);
        put(3'd5, 1, 5'd0, 32'd0, 32'd0, 32'h0000_7000);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(8);
        // Random mix; small register range provokes clashes
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 299) == 0) rst = 1'b1;
            else rst = 1'b0;
            if ($urandom_range(0, 99) < 85)
                put(3'($urandom), ($urandom_range(0, 9) < 8), 5'($urandom_range(0, 7)),
                    $urandom, $urandom, $urandom);
            else
                idle(1);
        end
        rst = 1'b0;
        idle(10);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule